// File: doc/BRIEF.md
# I2C Write-Only Control Latch Slave

This block is a Fast-mode I2C slave (SCL up to 400 kHz) that accepts write telegrams only and spreads the received bytes into control latches for a sound-IF front end. The latches hold the synthesizer divider ratio, a charge-pump current select, a 3-bit source/mode code, and 3-bit volume and pre-volume levels for the left and right channels. SCL and SDA are oversampled by the system clock. Each line passes through a two-flop synchronizer and a three-sample agreement filter before START, STOP and clock edges are detected.

The slave address has a pin-strapped least significant bit, so two devices can share one bus. After the address, data bytes arrive in pairs. The leading bit of the first byte of each pair (data bytes 1, 3, 5, ...) selects the pair type: divider or control. The second byte of a pair belongs to the same type. A divider ratio reaches the output only when both of its bytes have been received. The SDA pull-down output is held released during reset, so a device that is powering up cannot block the bus.

Top module: `i2c_ctl_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sda_pull_o` is 0. After reset, the divider ratio is 0, `pump_hi_o` is 0, `src_mode_o` is 3'b111 with `mute_o` high, and all four level outputs are 0.
- R2: An address byte whose upper seven bits equal 1100 01s (s = `addr_strap_i`) and whose bit 0 (direction) is 0 is acknowledged: `sda_pull_o` is high while SCL is high in the ninth clock.
- R3: An address byte that does not match, or that has direction bit 1, gets no acknowledge. The rest of the telegram is then ignored: no later byte is acknowledged and no output changes until the next START.
- R4: Every data byte of an addressed write telegram is acknowledged in its ninth clock.
- R5: A divider pair begins with a byte whose bit 7 is 0. The ratio becomes {first[6:0], second[7:0]} (15 bits), and it is updated only when the second byte arrives.
- R6: A telegram that ends with STOP after only the first byte of a divider pair leaves the divider ratio unchanged.
- R7: A control pair begins with a byte whose bit 7 is 1. Bit 6 sets `pump_hi_o` and bits 5:3 set `src_mode_o`. Both take effect as soon as that byte is received.
- R8: In the second control byte, bit 7 selects the target. With bit 7 = 0, bits 5:3 go to `vol_l_o` and bits 2:0 to `vol_r_o`. With bit 7 = 1, the same bits go to `pre_l_o` and `pre_r_o`.
- R9: Each pair is classified on its own, so a four-byte telegram can carry a control pair followed by a divider pair, or a divider pair followed by a control pair.
- R10: `mute_o` is high exactly when `src_mode_o` holds code 3'b111.
- R11: A repeated START restarts the address phase and discards a half-received divider pair.
- R12: The slave changes `sda_pull_o` only while SCL is low. It never drives SDA during the eight data bits of a byte, and it releases SDA at the falling edge that ends the ninth clock.
- R13: A pulse on SCL shorter than three system clocks is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap_i | input | 1 | Strap that sets address bit 0 |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| div_ratio_o | output | 15 | Committed synthesizer divider ratio |
| pump_hi_o | output | 1 | Charge-pump high-current select |
| src_mode_o | output | 3 | Source/mode code; 3'b111 = mute |
| mute_o | output | 1 | High when the mode code is mute |
| vol_l_o | output | 3 | Left volume level |
| vol_r_o | output | 3 | Right volume level |
| pre_l_o | output | 3 | Left pre-volume level |
| pre_r_o | output | 3 | Right pre-volume level |

## Verification
Most internal errors in this block show up on SDA within the same byte. A wrong bit count or phase puts the acknowledge pulse in the wrong clock, or drops it, in the very next ninth clock. A pair-position or type-flag error shows up only after STOP, as a value in the wrong latch or a divider built from the wrong halves. The bench therefore compares every latch output against an independent model after each telegram. A filter or edge-detection fault moves every later bit by one, so it corrupts the whole byte and its acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Source/mode code driven to the audio switch
  typedef enum logic [2:0] {
    SRC_STEREO = 3'd0,
    SRC_MONO_A = 3'd1,
    SRC_MONO_B = 3'd2,
    SRC_DE50   = 3'd3,
    SRC_DE75   = 3'd4,
    SRC_DEJ17  = 3'd5,
    SRC_EXT    = 3'd6,
    SRC_MUTE   = 3'd7
  } src_mode_e;

  // Telegram phase of the byte engine
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  // Pair type taken from bit 7 of the pair's first byte
  typedef enum logic {
    KIND_DIV  = 1'b0,
    KIND_CTRL = 1'b1
  } pair_kind_e;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   line_q;
  logic                   line_d;
  logic                   line_en;

  // The filtered level moves only when every sample in the window agrees
  always_comb begin
    line_d  = line_q;
    line_en = 1'b0;
    if (&hist_q) begin
      line_d  = 1'b1;
      line_en = 1'b1;
    end else if (~|hist_q) begin
      line_d  = 1'b0;
      line_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (line_en) line_q <= line_d;
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/i2cs_byte_engine.sv
module i2cs_byte_engine
  import i2cs_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b110001
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       strap_i,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       tel_start_o,
  output logic       sda_pull_o
);

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ACK_DONE  = CNT_W'(BYTE_BITS + 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       shift_q, shift_d;
  logic             pull_q, pull_d;
  logic             stb_q, stb_d;
  logic             start_q, start_d;
  logic             scl_q, sda_q;

  logic scl_rise, scl_fall, start_cond, stop_cond, addr_hit;

  assign scl_rise   = scl_i & ~scl_q;
  assign scl_fall   = ~scl_i & scl_q;
  assign start_cond = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_cond  = scl_i & scl_q & ~sda_q & sda_i;
  assign addr_hit   = (shift_q[7:1] == {ADDR_HI, strap_i}) && !shift_q[0];

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    pull_d  = pull_q;
    stb_d   = 1'b0;
    start_d = 1'b0;
    if (start_cond) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
      start_d = 1'b1;
    end else if (stop_cond) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (phase_q == PH_ADDR || phase_q == PH_DATA) begin
      if (scl_rise) begin
        if (cnt_q < LAST_DATA) shift_d = {shift_q[6:0], sda_i};
        cnt_d = cnt_q + 1'b1;
      end else if (scl_fall) begin
        if (cnt_q == LAST_DATA) begin
          if (phase_q == PH_ADDR) begin
            pull_d = addr_hit;
          end else begin
            pull_d = 1'b1;
            stb_d  = 1'b1;
          end
        end else if (cnt_q == ACK_DONE) begin
          pull_d = 1'b0;
          cnt_d  = '0;
          if (phase_q == PH_ADDR) phase_d = pull_q ? PH_DATA : PH_SKIP;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pull_q  <= 1'b0;
      stb_q   <= 1'b0;
      start_q <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      pull_q  <= pull_d;
      stb_q   <= stb_d;
      start_q <= start_d;
      scl_q   <= scl_i;
      sda_q   <= sda_i;
    end
  end

  assign byte_stb_o  = stb_q;
  assign byte_o      = shift_q;
  assign tel_start_o = start_q;
  assign sda_pull_o  = pull_q;

endmodule

// File: rtl/i2cs_ctrl_regs.sv
module i2cs_ctrl_regs
  import i2cs_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tel_start_i,
  input  logic             byte_stb_i,
  input  logic [7:0]       byte_i,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic             pump_hi_o,
  output src_mode_e        src_mode_o,
  output logic [LVL_W-1:0] vol_l_o,
  output logic [LVL_W-1:0] vol_r_o,
  output logic [LVL_W-1:0] pre_l_o,
  output logic [LVL_W-1:0] pre_r_o
);

  localparam int HI_W = DIV_W - 8;

  logic             second_q, second_d;
  pair_kind_e       kind_q, kind_d;
  logic [HI_W-1:0]  stash_q, stash_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pump_q, pump_d;
  src_mode_e        mode_q, mode_d;
  logic [LVL_W-1:0] vl_q, vl_d, vr_q, vr_d, pl_q, pl_d, pr_q, pr_d;
  logic [LVL_W-1:0] lvl_left, lvl_right;

  assign lvl_left  = byte_i[2*LVL_W-1:LVL_W];
  assign lvl_right = byte_i[LVL_W-1:0];

  always_comb begin
    second_d = second_q;
    kind_d   = kind_q;
    stash_d  = stash_q;
    div_d    = div_q;
    pump_d   = pump_q;
    mode_d   = mode_q;
    vl_d     = vl_q;
    vr_d     = vr_q;
    pl_d     = pl_q;
    pr_d     = pr_q;
    if (tel_start_i) begin
      second_d = 1'b0;
    end else if (byte_stb_i) begin
      if (!second_d) begin
        second_d = 1'b1;
        kind_d   = pair_kind_e'(byte_i[7]);
        if (byte_i[7] == KIND_DIV) begin
          stash_d = byte_i[HI_W-1:0];
        end else begin
          pump_d = byte_i[6];
          mode_d = src_mode_e'(byte_i[5:3]);
        end
      end else begin
        second_d = 1'b0;
        if (kind_q == KIND_DIV) begin
          div_d = {stash_q, byte_i};
        end else if (byte_i[7]) begin
          pl_d = lvl_left;
          pr_d = lvl_right;
        end else begin
          vl_d = lvl_left;
          vr_d = lvl_right;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      kind_q   <= KIND_DIV;
      stash_q  <= '0;
      div_q    <= '0;
      pump_q   <= 1'b0;
      mode_q   <= SRC_MUTE;
      vl_q     <= '0;
      vr_q     <= '0;
      pl_q     <= '0;
      pr_q     <= '0;
    end else begin
      second_q <= second_d;
      kind_q   <= kind_d;
      stash_q  <= stash_d;
      div_q    <= div_d;
      pump_q   <= pump_d;
      mode_q   <= mode_d;
      vl_q     <= vl_d;
      vr_q     <= vr_d;
      pl_q     <= pl_d;
      pr_q     <= pr_d;
    end
  end

  assign div_ratio_o = div_q;
  assign pump_hi_o   = pump_q;
  assign src_mode_o  = mode_q;
  assign vol_l_o     = vl_q;
  assign vol_r_o     = vr_q;
  assign pre_l_o     = pl_q;
  assign pre_r_o     = pr_q;

endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
  import i2cs_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b110001,
  parameter int         DIV_W       = 15,
  parameter int         LVL_W       = 3,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_strap_i,
  output logic             sda_pull_o,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic             pump_hi_o,
  output logic [2:0]       src_mode_o,
  output logic             mute_o,
  output logic [LVL_W-1:0] vol_l_o,
  output logic [LVL_W-1:0] vol_r_o,
  output logic [LVL_W-1:0] pre_l_o,
  output logic [LVL_W-1:0] pre_r_o
);

  localparam int N_LINES = 2;

  logic [1:0]         rst_pipe_q;
  logic               rst_n_sync;
  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic               scl_flt, sda_flt;
  logic               byte_stb, tel_start;
  logic [7:0]         byte_val;
  src_mode_e          mode_w;

  // Reset asserts at once, leaves two clocks later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cs_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_n_sync),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  i2cs_byte_engine #(
    .ADDR_HI(ADDR_HI)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .scl_i      (scl_flt),
    .sda_i      (sda_flt),
    .strap_i    (addr_strap_i),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_val),
    .tel_start_o(tel_start),
    .sda_pull_o (sda_pull_o)
  );

  i2cs_ctrl_regs #(
    .DIV_W(DIV_W),
    .LVL_W(LVL_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .tel_start_i(tel_start),
    .byte_stb_i (byte_stb),
    .byte_i     (byte_val),
    .div_ratio_o(div_ratio_o),
    .pump_hi_o  (pump_hi_o),
    .src_mode_o (mode_w),
    .vol_l_o    (vol_l_o),
    .vol_r_o    (vol_r_o),
    .pre_l_o    (pre_l_o),
    .pre_r_o    (pre_r_o)
  );

  assign src_mode_o = mode_w;
  assign mute_o     = (mode_w == SRC_MUTE);

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int DIV_W = 15,
  parameter int LVL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_f,
  input logic             pull,
  input logic             stb,
  input logic [DIV_W-1:0] div,
  input logic [2:0]       mode,
  input logic             pump,
  input logic [LVL_W-1:0] vl,
  input logic [LVL_W-1:0] vr,
  input logic [LVL_W-1:0] pl,
  input logic [LVL_W-1:0] pr
);

  // R12
  pull_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull) |-> !scl_f);

  // R12
  pull_hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && $past(scl_f)) |-> $stable(pull));

  // R5
  div_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div) |-> $past(stb));

  // R7
  mode_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pump, mode}) |-> $past(stb));

  // R8
  level_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({vl, vr, pl, pr}) |-> $past(stb));

endmodule

bind i2c_ctl_slave i2cs_checker #(
  .DIV_W(DIV_W),
  .LVL_W(LVL_W)
) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .scl_f (scl_flt),
  .pull  (sda_pull_o),
  .stb   (byte_stb),
  .div   (div_ratio_o),
  .mode  (src_mode_o),
  .pump  (pump_hi_o),
  .vl    (vol_l_o),
  .vr    (vol_r_o),
  .pl    (pre_l_o),
  .pr    (pre_r_o)
);

// File: tb/i2c_ctl_slave_tb_top.sv
module i2c_ctl_slave_tb_top;

  localparam int T = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m, strap;
  logic        sda_line;
  logic        pull;
  logic [14:0] div;
  logic        pump, mute;
  logic [2:0]  mode, vl, vr, pl, pr;

  int checks = 0;
  int fails  = 0;

  logic [14:0] e_div;
  logic        e_pump;
  logic [2:0]  e_mode, e_vl, e_vr, e_pl, e_pr;
  logic [6:0]  e_stash;
  logic        e_second, e_kind;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~pull;

  i2c_ctl_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap_i(strap), .sda_pull_o(pull), .div_ratio_o(div),
    .pump_hi_o(pump), .src_mode_o(mode), .mute_o(mute),
    .vol_l_o(vl), .vol_r_o(vr), .pre_l_o(pl), .pre_r_o(pr)
  );

  // addr, data1, data2
  localparam logic [23:0] VEC [0:7] = '{
    24'hC4_05A3, 24'hC4_C52A, 24'hC4_9FBC, 24'hC6_7711,
    24'hC5_0102, 24'hC4_B800, 24'hC4_7FFF, 24'hC4_0001
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R5 div"}, div, e_div);
    check({tag, " R7 pump"}, pump, e_pump);
    check({tag, " R7 mode"}, mode, e_mode);
    check({tag, " R10 mute"}, mute, (e_mode == 3'b111));
    check({tag, " R8 vol_l"}, vl, e_vl);
    check({tag, " R8 vol_r"}, vr, e_vr);
    check({tag, " R8 pre_l"}, pl, e_pl);
    check({tag, " R8 pre_r"}, pr, e_pr);
  endtask

  // Reference model of one data byte, built from R5, R7, R8, R9
  task automatic model_byte(input logic [7:0] b);
    if (!e_second) begin
      e_second = 1'b1;
      e_kind   = b[7];
      if (!b[7]) e_stash = b[6:0];
      else begin e_pump = b[6]; e_mode = b[5:3]; end
    end else begin
      e_second = 1'b0;
      if (!e_kind) e_div = {e_stash, b};
      else if (b[7]) begin e_pl = b[5:3]; e_pr = b[2:0]; end
      else begin e_vl = b[5:3]; e_vr = b[2:0]; end
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b0; tick(T);
    scl_m = 1'b0; tick(T);
    e_second = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(T);
    scl_m = 1'b1; tick(T);
    sda_m = 1'b1; tick(T);
  endtask

  // glitch_bit < 8 adds a one-clock SCL pulse in that bit's low phase
  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic acked);
    logic drove = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      tick(T / 2);
      if (glitch_bit == i) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; end
      tick(T / 2);
      scl_m = 1'b1; tick(T / 2);
      if (pull) drove = 1'b1;
      tick(T / 2);
      scl_m = 1'b0; tick(T);
    end
    check("R12 no drive in data bits", drove, 0);
    sda_m = 1'b1; tick(T);
    scl_m = 1'b1; tick(T / 2);
    acked = pull;
    tick(T / 2);
    scl_m = 1'b0; tick(T);
    check("R12 release after ninth", pull, 0);
  endtask

  task automatic send_addr(input logic [7:0] a, output logic hit);
    logic ack;
    hit = (a[7:1] == {6'b110001, strap}) && !a[0];
    send_byte(a, 99, ack);
    check(hit ? "R2 addr ack" : "R3 addr nack", ack, hit);
  endtask

  task automatic send_data(input logic [7:0] b, input logic hit, input int gb);
    logic ack;
    send_byte(b, gb, ack);
    check(hit ? "R4 data ack" : "R3 ignored data", ack, hit);
    if (hit) model_byte(b);
  endtask

  initial begin
    logic hit;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap = 1'b0;
    e_div = '0; e_pump = 1'b0; e_mode = 3'b111;
    e_vl = '0; e_vr = '0; e_pl = '0; e_pr = '0;
    e_stash = '0; e_second = 1'b0; e_kind = 1'b0;
    tick(6);
    check("R1 sda released in reset", pull, 0);
    rst_n = 1'b1;
    tick(20);
    check("R1 sda released after reset", pull, 0);
    check_all("R1 reset");

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      bus_start();
      send_addr(VEC[v][23:16], hit);
      send_data(VEC[v][15:8], hit, 99);
      send_data(VEC[v][7:0], hit, 99);
      bus_stop();
      tick(4 * T);
      check_all("vector");
    end

    // R6: divider half only
    bus_start();
    send_addr(8'hC4, hit);
    send_data(8'h12, hit, 99);
    bus_stop();
    tick(4 * T);
    check("R6 half divider kept", div, e_div);

    // R9: control pair then divider pair in one telegram
    bus_start();
    send_addr(8'hC4, hit);
    send_data(8'h85, hit, 99);
    send_data(8'h1B, hit, 99);
    send_data(8'h03, hit, 99);
    send_data(8'h44, hit, 99);
    bus_stop();
    tick(4 * T);
    check("R9 mixed div", div, 15'h0344);
    check_all("R9 mixed");

    // R11: repeated START discards half divider pair
    bus_start();
    send_addr(8'hC4, hit);
    send_data(8'h01, hit, 99);
    bus_start();
    send_addr(8'hC4, hit);
    send_data(8'hF0, hit, 99);
    send_data(8'h80, hit, 99);
    bus_stop();
    tick(4 * T);
    check("R11 mode after restart", mode, 3'b110);
    check_all("R11 restart");

    // R13: short SCL pulse inside a bit
    bus_start();
    send_addr(8'hC4, hit);
    send_data(8'h22, hit, 99);
    send_data(8'h5C, hit, 3);
    bus_stop();
    tick(4 * T);
    check("R13 glitch ignored", div, 15'h225C);

    // R2: strap high moves the address
    strap = 1'b1;
    tick(4 * T);
    bus_start();
    send_addr(8'hC4, hit);
    send_data(8'h00, hit, 99);
    send_data(8'h07, hit, 99);
    bus_stop();
    bus_start();
    send_addr(8'hC6, hit);
    send_data(8'h11, hit, 99);
    send_data(8'h22, hit, 99);
    bus_stop();
    tick(4 * T);
    check("R2 strap address div", div, 15'h1122);
    check_all("R2 strap");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule